// File: doc/BRIEF.md
# DMA Channel Termination Sequencer

This block runs one DMA channel that copies data by dual-address transfer. Each transfer unit is a read from the source side and then a write of the same word to the destination side. The channel takes requests in two service styles. In cycle-steal mode it does one unit per request and gives the bus back between units. In burst mode it keeps the bus and chains units back to back. Requests are recognised either by level or by rising edge.

The main concern of the block is stopping cleanly. There are three end conditions: the unit count reaches zero, software clears the channel enable, or the global master enable drops. After any of them the channel accepts no new request. It still finishes the unit it has in flight, and it never separates a read from its write. An end condition is looked at only where a request would be looked at: in the idle cycle, or on the write handshake that closes a burst unit. For that reason a stop takes effect after the same number of units in both service styles. A burst started by an edge carries on by itself until one of these stop checks fails.

Top module: `dma_term_seq`

## Requirements
- R1: While rst_ni is low and immediately after reset: rd_o=0, wr_o=0, ch_en_o=0, count_o=0, done_o=0.
- R2: A cnt_wr_i write loads count_o only while the channel is halted (ch_en_o=0). While enabled, the write is ignored and count_o keeps its value.
- R3: Writing en_wdata_i=1 with en_wr_i sets ch_en_o only if count_o is non-zero and mst_en_i=1. Otherwise ch_en_o stays 0.
- R4: Unit k (k=0 after each enable) reads at src_addr_i+k*STEP until rdy_i is high, and then always writes the captured rdata_i to dst_addr_i+k*STEP until rdy_i is high. The read and the write of one unit are never split.
- R5: count_o falls by one at every write handshake. When it reaches zero, ch_en_o clears, done_o sets and no further read starts.
- R6: In cycle-steal mode (burst_i=0), the cycle after a write handshake has neither rd_o nor wr_o asserted.
- R7: In burst mode, if the channel continues, rd_o is asserted in the cycle right after the write handshake.
- R8: In burst mode with edge detection (edge_i=1), one rising edge of req_i runs units until an end condition, even with req_i held low.
- R9: In level mode (edge_i=0), req_i is looked at in the idle cycle and, in burst mode, in the write-handshake cycle. If it is low, the channel stays enabled and idle and count_o does not change.
- R10: Clearing the channel enable during a read still completes that unit. count_o ends exactly one lower than it was at the read, and no later unit starts.
- R11: Dropping mst_en_i during a unit completes that unit and then clears ch_en_o. Raising mst_en_i again does not restart the channel without a new enable write.
- R12: With edge detection, a rising edge seen while the channel is armed is held as a pending request until a unit accepts it. Edges seen while halted are discarded.
- R13: done_o stays set after a terminal-count stop and clears when an enable write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| burst_i | input | 1 | 1 = burst, 0 = cycle steal |
| edge_i | input | 1 | 1 = rising-edge detection, 0 = level |
| mst_en_i | input | 1 | Global master enable |
| en_wr_i | input | 1 | Channel enable write strobe |
| en_wdata_i | input | 1 | Value written to the channel enable |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | CW | Count value to load |
| src_addr_i | input | AW | Source base address |
| dst_addr_i | input | AW | Destination base address |
| rd_o | output | 1 | Read strobe, held until rdy_i |
| wr_o | output | 1 | Write strobe, held until rdy_i |
| addr_o | output | AW | Bus address |
| rdata_i | input | DW | Read data |
| wdata_o | output | DW | Write data |
| rdy_i | input | 1 | Bus ready, completes the current strobe |
| ch_en_o | output | 1 | Channel enable state |
| count_o | output | CW | Remaining transfer units |
| done_o | output | 1 | Halted on terminal count |

## Verification
The hardest case to reach is a stop that arrives while a unit is half done. The enable or the master enable has to fall after the read has begun but before its write has finished. The stimulus waits until it sees rd_o asserted and then clears the enable bit in that cycle, while the bus slave adds random ready delays. The bench then checks that exactly one more write takes place. A burst run in level mode is stopped by lowering req_i in the middle of the run. This leaves the channel enabled but idle, and in that state a count write can be offered to show that it is ignored.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } dma_st_e;
endpackage

// File: rtl/dma_req_unit.sv
module dma_req_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic edge_i,
  input  logic arm_i,
  input  logic take_i,
  output logic go_o
);
  logic req_q, pend_q, rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q <= req_i;
      if (!arm_i)      pend_q <= 1'b0;
      else if (rise)   pend_q <= 1'b1;
      else if (take_i) pend_q <= 1'b0;
    end
  end

  assign go_o = edge_i ? pend_q : req_i;

  // pending edge survives until a unit takes it
  a_r12_pend_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && pend_q && !take_i) |=> pend_q);
endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= ld_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CW'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CW'(1));
  assign zero_o = (cnt_q == '0);

  a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);
  a_r2_cnt_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int AW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic          sel_wr_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  logic [AW-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (clr_i)  off_q <= '0;
    else if (adv_i)  off_q <= off_q + STEP_V;
  end

  assign addr_o = (sel_wr_i ? dst_i : src_i) + off_q;
endmodule

// File: rtl/dma_term_seq.sv
module dma_term_seq
  import dma_term_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int CW   = 8,
  parameter int STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          burst_i,
  input  logic          edge_i,
  input  logic          mst_en_i,
  input  logic          en_wr_i,
  input  logic          en_wdata_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  output logic          rd_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] wdata_o,
  input  logic          rdy_i,
  output logic          ch_en_o,
  output logic [CW-1:0] count_o,
  output logic          done_o
);
  dma_st_e       st_q, st_d;
  logic          ch_en_q, done_q;
  logic [DW-1:0] buf_q;
  logic          go, cnt_last, cnt_zero, cnt_load;
  logic          rd_hs, wr_hs, active, start, cont_ok, cont, take, en_set;

  assign rd_hs  = (st_q == ST_RD) & rdy_i;
  assign wr_hs  = (st_q == ST_WR) & rdy_i;
  assign active = ch_en_q & mst_en_i & ~cnt_zero;
  assign start  = (st_q == ST_IDLE) & active & go;
  // stop sampled where a request would be: at the closing write handshake
  assign cont_ok = ch_en_q & mst_en_i & ~cnt_last & (edge_i | req_i);
  assign cont    = wr_hs & burst_i & cont_ok;
  assign take    = start | cont;
  assign en_set  = en_wr_i & en_wdata_i & ~ch_en_q & (st_q == ST_IDLE)
                 & mst_en_i & ~cnt_zero;
  assign cnt_load = cnt_wr_i & ~ch_en_q & (st_q == ST_IDLE);

  dma_req_unit u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .edge_i (edge_i),
    .arm_i  (ch_en_q & mst_en_i),
    .take_i (take),
    .go_o   (go)
  );

  dma_cnt_unit #(.CW(CW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cnt_load),
    .ld_val_i (cnt_wdata_i),
    .dec_i    (wr_hs),
    .cnt_o    (count_o),
    .last_o   (cnt_last),
    .zero_o   (cnt_zero)
  );

  dma_addr_unit #(.AW(AW), .STEP(STEP)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (en_set),
    .adv_i    (wr_hs),
    .sel_wr_i (st_q == ST_WR),
    .src_i    (src_addr_i),
    .dst_i    (dst_addr_i),
    .addr_o   (addr_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_RD;
      ST_RD:   if (rdy_i) st_d = ST_WR;
      ST_WR:   if (rdy_i) st_d = cont ? ST_RD : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ch_en_q <= 1'b0;
      done_q  <= 1'b0;
      buf_q   <= '0;
    end else begin
      st_q <= st_d;
      if (rd_hs) buf_q <= rdata_i;
      if (en_set)                         ch_en_q <= 1'b1;
      else if (en_wr_i && !en_wdata_i)    ch_en_q <= 1'b0;
      else if (wr_hs && cnt_last)         ch_en_q <= 1'b0;
      else if (st_q == ST_IDLE && !mst_en_i) ch_en_q <= 1'b0;
      if (en_set)                 done_q <= 1'b0;
      else if (wr_hs && cnt_last) done_q <= 1'b1;
    end
  end

  assign rd_o    = (st_q == ST_RD);
  assign wr_o    = (st_q == ST_WR);
  assign wdata_o = buf_q;
  assign ch_en_o = ch_en_q;
  assign done_o  = done_q;

  a_r4_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && rdy_i) |=> wr_o);
  a_r4_write_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !rdy_i) |=> (wr_o && $stable(wdata_o) && $stable(addr_o)));
  a_r6_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && rdy_i && !burst_i) |=> (!rd_o && !wr_o));
  a_r5_terminal_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && rdy_i && count_o == CW'(1)) |=> (!ch_en_o && done_o && !rd_o));
  a_r10_no_start_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ch_en_o && !rd_o && !wr_o) |=> !rd_o);
  a_r13_done_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> ch_en_o);
endmodule

// File: tb/dma_term_seq_bench.sv
`timescale 1ns/1ps
module dma_term_seq_bench;
  localparam int AW = 16, DW = 32, CW = 8, STEP = 4;
  localparam logic [AW-1:0] SRC = 16'h1000, DST = 16'h8000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, burst_i = 0, edge_i = 0, mst_en_i = 1;
  logic en_wr_i = 0, en_wdata_i = 0, cnt_wr_i = 0, rdy_i = 0;
  logic [CW-1:0] cnt_wdata_i = '0;
  logic [DW-1:0] rdata_i = '0;
  logic rd_o, wr_o, ch_en_o, done_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] wdata_o;
  logic [CW-1:0] count_o;

  int checks = 0, errors = 0, units = 0, k = 0, cyc = 0;
  bit gap_pend = 0, cont_pend = 0;

  always #2.5 clk = ~clk;

  dma_term_seq #(.AW(AW), .DW(DW), .CW(CW), .STEP(STEP)) u_dma_term_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .burst_i(burst_i), .edge_i(edge_i),
    .mst_en_i(mst_en_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .src_addr_i(SRC), .dst_addr_i(DST),
    .rd_o(rd_o), .wr_o(wr_o), .addr_o(addr_o), .rdata_i(rdata_i), .wdata_o(wdata_o),
    .rdy_i(rdy_i), .ch_en_o(ch_en_o), .count_o(count_o), .done_o(done_o));

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // bus slave and unit monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (gap_pend) chk(!rd_o && !wr_o, "R6", "idle cycle after unit", int'(rd_o | wr_o), 0);
      if (cont_pend) chk(rd_o, "R7", "burst read follows write", int'(rd_o), 1);
      gap_pend = 0; cont_pend = 0;
      rdy_i = 1'b0;
      if (rd_o || wr_o) rdy_i = ($urandom % 3) != 0;
      if (rd_o) begin
        rdata_i = pat(addr_o);
        if (rdy_i) chk(addr_o == SRC + AW'(k * STEP), "R4", "read address", int'(addr_o), int'(SRC + AW'(k * STEP)));
      end
      if (wr_o && rdy_i) begin
        chk(addr_o == DST + AW'(k * STEP), "R4", "write address", int'(addr_o), int'(DST + AW'(k * STEP)));
        chk(wdata_o == pat(SRC + AW'(k * STEP)), "R4", "write data", int'(wdata_o), int'(pat(SRC + AW'(k * STEP))));
        gap_pend  = !burst_i;
        cont_pend = burst_i && ch_en_o && mst_en_i && !en_wr_i && count_o > 1 && (edge_i || req_i);
        k++; units++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      chk(0, "watchdog", "run timed out", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic load(input int n);
    tick(); cnt_wr_i = 1; cnt_wdata_i = CW'(n); tick(); cnt_wr_i = 0;
  endtask

  task automatic enable();
    tick(); en_wr_i = 1; en_wdata_i = 1; k = 0; tick(); en_wr_i = 0;
  endtask

  task automatic disable_ch();
    en_wr_i = 1; en_wdata_i = 0; tick(); en_wr_i = 0;
  endtask

  task automatic pulse(); tick(); req_i = 1; tick(); req_i = 0; endtask

  task automatic wait_halt(input string rq);
    bit hit = 0;
    for (int i = 0; i < 3000; i++) begin
      tick();
      if (!ch_en_o && !rd_o && !wr_o) begin hit = 1; break; end
    end
    if (!hit) chk(0, rq, "channel did not halt", int'(ch_en_o), 0);
  endtask

  task automatic wait_units(input int n);
    for (int i = 0; i < 500 && units < n; i++) tick();
  endtask

  task automatic wait_rd();
    for (int i = 0; i < 500 && !rd_o; i++) tick();
  endtask

  task automatic job(input bit b, input bit e, input int n, input string rq);
    burst_i = b; edge_i = e; units = 0;
    load(n); enable();
    chk(done_o == 0, "R13", "done cleared on enable", int'(done_o), 0);
    if (!e) begin req_i = 1; wait_halt(rq); req_i = 0; end
    else if (b) begin pulse(); wait_halt(rq); end
    else begin
      for (int i = 0; i < n; i++) begin pulse(); wait_units(i + 1); end
      wait_halt(rq);
    end
    chk(units == n, rq, "units moved", units, n);
    chk(count_o == 0, "R5", "count at halt", int'(count_o), 0);
    chk(done_o == 1, "R5", "done at terminal count", int'(done_o), 1);
  endtask

  initial begin
    int c;
    void'($urandom(32'd1234));
    #1;
    chk(!rd_o && !wr_o && !ch_en_o && count_o == 0 && !done_o, "R1", "outputs in reset", int'(count_o), 0);
    repeat (3) tick();
    rst_ni = 1;
    tick();
    chk(!rd_o && !wr_o && !ch_en_o && !done_o, "R1", "state after reset", int'(ch_en_o), 0);

    // R3: enable refused with zero count or master off
    enable();
    chk(ch_en_o == 0, "R3", "enable with zero count", int'(ch_en_o), 0);
    load(4);
    chk(count_o == 4, "R2", "load while halted", int'(count_o), 4);
    mst_en_i = 0; enable();
    chk(ch_en_o == 0, "R3", "enable with master off", int'(ch_en_o), 0);
    mst_en_i = 1;

    // directed jobs in each mode
    job(0, 0, 3, "R6");
    job(0, 1, 3, "R12");
    job(1, 1, 5, "R8");
    job(1, 0, 4, "R7");

    // R12: edge while halted is dropped, edge while armed is kept
    burst_i = 0; edge_i = 1; units = 0;
    load(3); pulse(); enable();
    repeat (20) tick();
    chk(count_o == 3 && units == 0, "R12", "halted edge discarded", int'(count_o), 3);
    pulse(); wait_units(1); repeat (10) tick();
    chk(count_o == 2, "R12", "armed edge served", int'(count_o), 2);
    tick(); disable_ch();

    // R9 and R2: burst level paused by low request
    burst_i = 1; edge_i = 0; units = 0;
    load(20); enable(); req_i = 1;
    wait_units(3); req_i = 0;
    repeat (15) tick(); c = int'(count_o);
    repeat (15) tick();
    chk(int'(count_o) == c, "R9", "count stable while request low", int'(count_o), c);
    chk(ch_en_o == 1 && done_o == 0 && !rd_o && !wr_o, "R9", "enabled idle", int'(ch_en_o), 1);
    chk(c == 20 - units, "R9", "count matches units", c, 20 - units);
    cnt_wr_i = 1; cnt_wdata_i = 8'd99; tick(); cnt_wr_i = 0; tick();
    chk(int'(count_o) == c, "R2", "load ignored while enabled", int'(count_o), c);
    req_i = 1; wait_halt("R9"); req_i = 0;
    chk(units == 20 && done_o == 1, "R9", "resumed run completes", units, 20);

    // R10: clear channel enable during a read
    burst_i = 0; edge_i = 0; units = 0;
    load(6); enable(); req_i = 1;
    wait_units(2); wait_rd();
    c = int'(count_o);
    disable_ch(); req_i = 0;
    wait_halt("R10"); repeat (10) tick();
    chk(int'(count_o) == c - 1, "R10", "in-flight unit finished", int'(count_o), c - 1);
    chk(done_o == 0 && ch_en_o == 0, "R10", "stopped without done", int'(done_o), 0);

    // R11: master enable dropped in burst edge mode
    burst_i = 1; edge_i = 1; units = 0;
    load(8); enable(); pulse();
    wait_units(2); wait_rd();
    c = int'(count_o);
    mst_en_i = 0;
    wait_halt("R11"); repeat (5) tick();
    chk(int'(count_o) == c - 1, "R11", "unit completes after master drop", int'(count_o), c - 1);
    mst_en_i = 1; repeat (10) tick();
    chk(ch_en_o == 0 && int'(count_o) == c - 1, "R11", "no restart without enable write", int'(ch_en_o), 0);
    units = 0; enable(); pulse(); wait_halt("R11");
    chk(units == c - 1 && done_o == 1, "R11", "restarted run finishes", units, c - 1);

    // constrained random jobs
    for (int j = 0; j < 16; j++) begin
      bit b, e;
      int n;
      b = $urandom % 2; e = $urandom % 2; n = 1 + ($urandom % 6);
      job(b, e, n, "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule